// File: doc/BRIEF.md
# SDRAM burst column address generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller pulses a start strobe together with the starting column and the access direction. The block then steps through the burst one beat per enabled clock and flags the final beat. The burst length, the burst ordering and the single-beat write override are supplied as the raw mode-register field codes, and the block decodes them itself. It captures the decoded settings when a burst starts, so later field changes do not disturb a burst that is already running.

Two orderings are supported. Sequential order counts the low column bits upward and wraps inside the block aligned to the burst length. Interleaved order XORs the beat number into those same low bits. The column bits above the burst field stay fixed. A full-page burst walks the whole page and wraps until it is stopped. A burst can be cut short by a stop strobe, or it can be replaced at any time by a new start. Holding the clock-enable input low freezes the block completely.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The length code decodes as 000 to 1 beat, 001 to 2 beats, 010 to 4 beats, 011 to 8 beats and 111 to full page. The decoded length and ordering are captured at the start strobe.
- R2: With the ordering input at 0 (sequential), beat n has low log2(BL) bits equal to (start + n) mod BL, and the higher column bits equal those of the start column. For example, BL=4 starting at 0x52 gives 0x52, 0x53, 0x50, 0x51.
- R3: With the ordering input at 1 (interleaved), beat n has low log2(BL) bits equal to start XOR n, and the higher bits are unchanged. For example, BL=8 starting at 0x35 gives 0x35, 0x34, 0x37, 0x36, 0x31, 0x30, 0x33, 0x32.
- R4: When the single-write input is 1, a write burst lasts exactly one beat whatever the length code is. A read burst still uses the programmed length.
- R5: A full-page burst increments the column modulo 256 (for the 8-bit column), wrapping across the page, until it is stopped or restarted. Its ordering input is ignored, and the order is always sequential.
- R6: The last flag is 1 exactly on beat BL-1 and never during a full-page burst. The beat-valid output falls on the cycle after the final beat unless a new start arrives.
- R7: A stop strobe during a burst makes beat-valid 0 from the next cycle. A stop strobe while idle has no effect.
- R8: A start is accepted on any enabled cycle, including mid-burst and on the last beat. The first beat, equal to the start column, appears on the next cycle with no gap. A start wins over a stop given in the same cycle.
- R9: While clock-enable is low, the column, beat-valid and last outputs hold their values, and start and stop strobes are ignored.
- R10: A start carrying a reserved length code (100, 101, 110) is ignored, and no burst begins.
- R11: After reset, beat-valid is 0, last is 0 and the column is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; low freezes all state |
| start_i | input | 1 | Start a new burst |
| start_col_i | input | COL_W | Starting column |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read |
| stop_i | input | 1 | End the running burst |
| bl_code_i | input | 3 | Burst length field code |
| ilv_i | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| wr_single_i | input | 1 | 1 forces single-beat writes |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A burst beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
A restart and a burst end can fall in the same cycle. One case is a start and a stop strobe driven together mid-burst. The other is a start issued while the last flag is high. The bench provokes both. It judges them by requiring beat-valid to stay high on the following cycle, with the new start column as beat 0 and the new ordering after it. A start presented while clock-enable is low is also driven, to check that the suspension masks it.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EGT  = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  function automatic logic bl_code_legal(input logic [2:0] code);
    return (code[2] == 1'b0) || (code == BL_PAGE);
  endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  input  logic             is_write_i,
  output logic             legal_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] mask_o
);
  import colgen_pkg::*;

  logic [1:0] lg;
  logic       page;

  always_comb begin
    lg   = 2'd0;
    page = 1'b0;
    case (bl_code_i)
      BL_ONE:  lg = 2'd0;
      BL_TWO:  lg = 2'd1;
      BL_FOUR: lg = 2'd2;
      BL_EGT:  lg = 2'd3;
      BL_PAGE: page = 1'b1;
      default: lg = 2'd0;
    endcase
    if (is_write_i && wr_single_i) begin
      lg   = 2'd0;
      page = 1'b0;
    end
  end

  assign legal_o = bl_code_legal(bl_code_i);
  assign full_o  = page;
  assign ilv_o   = ilv_i & ~page;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = page | (i < int'(lg));
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             legal_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic             last_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o
);

  logic             active_q, active_d;
  logic             full_q, full_d;
  logic             ilv_q, ilv_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             at_end;
  logic             take;

  assign at_end = active_q & ~full_q & (cnt_q == mask_q);
  assign take   = cke_i & start_i & legal_i;

  always_comb begin
    active_d = active_q;
    full_d   = full_q;
    ilv_d    = ilv_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    mask_d   = mask_q;
    if (take) begin
      active_d = 1'b1;
      full_d   = full_i;
      ilv_d    = ilv_i;
      base_d   = start_col_i;
      cnt_d    = '0;
      mask_d   = mask_i;
    end else if (cke_i && active_q) begin
      if (stop_i || at_end) begin
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else begin
      active_q <= active_d;
      full_q   <= full_d;
      ilv_q    <= ilv_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      mask_q   <= mask_d;
    end
  end

  assign active_o = active_q;
  assign last_o   = at_end;
  assign ilv_o    = ilv_q;
  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;

  assign sum = base_i + cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (ilv_i ? (base_i[i] ^ cnt_i[i]) : sum[i])
                                : base_i[i];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             is_write_i,
  input  logic             stop_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o
);

  logic             rst_meta_n, rst_sync_n;
  logic             dec_legal, dec_full, dec_ilv;
  logic [COL_W-1:0] dec_mask;
  logic             q_ilv;
  logic [COL_W-1:0] q_base, q_cnt, q_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  colgen_mode_dec #(.COL_W(COL_W)) u_dec (
    .bl_code_i   (bl_code_i),
    .ilv_i       (ilv_i),
    .wr_single_i (wr_single_i),
    .is_write_i  (is_write_i),
    .legal_o     (dec_legal),
    .full_o      (dec_full),
    .ilv_o       (dec_ilv),
    .mask_o      (dec_mask)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cke_i       (cke_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .legal_i     (dec_legal),
    .full_i      (dec_full),
    .ilv_i       (dec_ilv),
    .mask_i      (dec_mask),
    .active_o    (beat_valid_o),
    .last_o      (last_o),
    .ilv_o       (q_ilv),
    .base_o      (q_base),
    .cnt_o       (q_cnt),
    .mask_o      (q_mask)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i (q_base),
    .cnt_i  (q_cnt),
    .mask_i (q_mask),
    .ilv_i  (q_ilv),
    .col_o  (col_o)
  );

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cke_i,
  input logic             start_i,
  input logic             stop_i,
  input logic [2:0]       bl_code_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_valid_o,
  input logic             last_o
);

  logic code_ok;
  assign code_ok = (bl_code_i[2] == 1'b0) || (bl_code_i == 3'b111);

  // R9: suspension freezes outputs
  assert_hold_on_suspend_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cke_i |=> ($stable(col_o) && $stable(beat_valid_o) && $stable(last_o)));

  // R6: last flag only during a burst
  assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last_o |-> beat_valid_o);

  // R6: burst ends after last beat
  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_o && cke_i && !start_i) |=> !beat_valid_o);

  // R7: stop ends the burst
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop_i && cke_i && !start_i) |=> !beat_valid_o);

  // R8: accepted start presents its column next cycle
  assert_start_first_beat_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && cke_i && code_ok) |=> (beat_valid_o && col_o == $past(start_col_i)));

  // R10: reserved code does not open a burst from idle
  assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && cke_i && !code_ok && !beat_valid_o) |=> !beat_valid_o);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cke_i        (cke_i),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .bl_code_i    (bl_code_i),
  .start_col_i  (start_col_i),
  .col_o        (col_o),
  .beat_valid_o (beat_valid_o),
  .last_o       (last_o)
);

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cke_i = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic             is_write_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [2:0]       bl_code_i = 3'b000;
  logic             ilv_i = 1'b0;
  logic             wr_single_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_valid_o;
  logic             last_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .start_i(start_i),
    .start_col_i(start_col_i), .is_write_i(is_write_i), .stop_i(stop_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .wr_single_i(wr_single_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .last_o(last_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // lg: log2 of length, 8 means full page
  function automatic int exp_col(input int base, input int n, input int lg, input bit ilv);
    int blk, lo, hi;
    if (lg == 8) return (base + n) % 256;
    blk = 1 << lg;
    lo  = base % blk;
    hi  = base - lo;
    if (ilv) return hi + (lo ^ n);
    return hi + ((lo + n) % blk);
  endfunction

  task automatic pulse_start(input int col, input bit wr, input logic [2:0] code,
                             input bit ilv, input bit sw);
    start_i = 1'b1; start_col_i = col[COL_W-1:0]; is_write_i = wr;
    bl_code_i = code; ilv_i = ilv; wr_single_i = sw;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic walk(input string tag, input int base, input int nb, input int lg,
                      input bit ilv, input bit page);
    for (int n = 0; n < nb; n++) begin
      chk({tag, " valid"}, beat_valid_o, 1);
      chk({tag, " col"}, col_o, exp_col(base, n, lg, ilv));
      chk({tag, " last"}, last_o, (!page && n == nb - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R11 reset valid", beat_valid_o, 0);
    chk("R11 reset last", last_o, 0);
    chk("R11 reset col", col_o, 0);
  endtask

  task automatic t_seq_lengths;
    pulse_start(8'h52, 0, 3'b010, 0, 0); walk("R2 seq bl4", 8'h52, 4, 2, 0, 0);
    chk("R6 end bl4", beat_valid_o, 0);
    pulse_start(8'hA7, 0, 3'b000, 0, 0); walk("R1 seq bl1", 8'hA7, 1, 0, 0, 0);
    chk("R1 end bl1", beat_valid_o, 0);
    pulse_start(8'h13, 0, 3'b001, 0, 0); walk("R1 seq bl2", 8'h13, 2, 1, 0, 0);
    chk("R1 end bl2", beat_valid_o, 0);
    pulse_start(8'hCD, 0, 3'b011, 0, 0); walk("R2 seq bl8", 8'hCD, 8, 3, 0, 0);
    chk("R6 end bl8", beat_valid_o, 0);
  endtask

  task automatic t_ilv;
    pulse_start(8'h35, 0, 3'b011, 1, 0); walk("R3 ilv bl8", 8'h35, 8, 3, 1, 0);
    chk("R3 end", beat_valid_o, 0);
    pulse_start(8'h9E, 0, 3'b010, 1, 0); walk("R3 ilv bl4", 8'h9E, 4, 2, 1, 0);
    chk("R3 end bl4", beat_valid_o, 0);
  endtask

  task automatic t_single_write;
    pulse_start(8'h44, 1, 3'b011, 0, 1); walk("R4 single wr", 8'h44, 1, 0, 0, 0);
    chk("R4 wr end", beat_valid_o, 0);
    pulse_start(8'h44, 0, 3'b011, 0, 1); walk("R4 read full len", 8'h44, 8, 3, 0, 0);
    chk("R4 rd end", beat_valid_o, 0);
    pulse_start(8'h61, 1, 3'b010, 0, 0); walk("R4 wr normal", 8'h61, 4, 2, 0, 0);
    chk("R4 wr normal end", beat_valid_o, 0);
  endtask

  task automatic t_full_page;
    pulse_start(8'hFE, 0, 3'b111, 0, 0); walk("R5 page", 8'hFE, 260, 8, 0, 1);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R7 page stop", beat_valid_o, 0);
    pulse_start(8'h05, 0, 3'b111, 1, 0); walk("R5 page ilv ignored", 8'h05, 12, 8, 0, 1);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R7 page stop2", beat_valid_o, 0);
  endtask

  task automatic t_stop;
    pulse_start(8'h40, 0, 3'b011, 0, 0); walk("R7 pre", 8'h40, 3, 3, 0, 1);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R7 stopped", beat_valid_o, 0);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R7 idle stop", beat_valid_o, 0);
    pulse_start(8'h22, 0, 3'b001, 0, 0); walk("R7 after idle stop", 8'h22, 2, 1, 0, 0);
    chk("R7 end", beat_valid_o, 0);
  endtask

  task automatic t_restart;
    pulse_start(8'h10, 0, 3'b010, 0, 0); walk("R8 pre", 8'h10, 2, 2, 0, 1);
    stop_i = 1'b1;
    pulse_start(8'h26, 0, 3'b010, 0, 0);
    stop_i = 1'b0;
    walk("R8 start beats stop", 8'h26, 4, 2, 0, 0);
    chk("R8 end a", beat_valid_o, 0);
    pulse_start(8'h81, 0, 3'b001, 0, 0); walk("R8 first", 8'h81, 1, 1, 0, 1);
    chk("R8 on last flag", last_o, 1);
    pulse_start(8'hB6, 0, 3'b011, 1, 0); walk("R8 gapless", 8'hB6, 8, 3, 1, 0);
    chk("R8 end b", beat_valid_o, 0);
  endtask

  task automatic t_suspend;
    pulse_start(8'h70, 0, 3'b011, 0, 0); walk("R9 pre", 8'h70, 2, 3, 0, 1);
    cke_i = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R9 hold col", col_o, 8'h72);
      chk("R9 hold valid", beat_valid_o, 1);
      start_i = 1'b1; start_col_i = 8'h0F; stop_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;
    chk("R9 still held", col_o, 8'h72);
    cke_i = 1'b1;
    @(negedge clk);
    for (int n = 3; n < 8; n++) begin
      chk("R9 resume col", col_o, exp_col(8'h70, n, 3, 0));
      chk("R9 resume last", last_o, (n == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9 end", beat_valid_o, 0);
  endtask

  task automatic t_reserved;
    pulse_start(8'h33, 0, 3'b100, 0, 0);
    chk("R10 code100", beat_valid_o, 0);
    pulse_start(8'h33, 0, 3'b110, 0, 0);
    chk("R10 code110", beat_valid_o, 0);
    @(negedge clk);
    chk("R10 still idle", beat_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_seq_lengths;
    t_ilv;
    t_single_write;
    t_full_page;
    t_stop;
    t_restart;
    t_suspend;
    t_reserved;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule